// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Register Bank

This block is the interrupt side of an SPI controller's register file. It sits on a plain 32-bit register bus with byte addresses and word offsets. It latches event pulses raised by the shift engine and the FIFOs, shows the live FIFO level conditions, and keeps a per-source mask. It drives a single interrupt line that is high whenever an enabled source is pending.

Software changes the mask through two write-only offsets. One of them sets mask bits wherever the written data has ones. The other clears mask bits wherever the written data has ones. The resulting mask can be read back from a separate offset. Latched event bits are cleared by writing ones to the status offset.

The block also decodes the two data offsets. A write to the transmit-data offset produces a push strobe carrying the low byte. A read of the receive-data offset produces a pop strobe and returns the receive byte. The FIFOs and the shift engine are outside the block.

Top module: `spi_irq_regbank`

## Requirements
- R1: After reset the mask is all zeros, every event status bit is zero and `irq` is low.
- R2: A write to offset 0x08 sets each mask bit whose data bit is one and leaves the other mask bits as they were. The new mask reads back at offset 0x10 in bits [6:0] from the next cycle on.
- R3: A write to offset 0x0C clears each mask bit whose data bit is one and leaves the other mask bits as they were. Writing 0x7F masks every source.
- R4: Status bits 0, 1, 3, 5 and 6 are event bits. A one on the matching bit of `evt_pulse` sets the bit from the next cycle on, and the bit stays set until it is cleared by a write of one to offset 0x04. An event that arrives in the same cycle as its clear leaves the bit set.
- R5: Status bit 4 always equals `rx_not_empty` and bit 2 always equals `tx_not_full`, in the same cycle. Writes to 0x04 and pulses on `evt_pulse` do not change these bits.
- R6: `irq` is high exactly when some bit of (status AND mask) is one. It follows status and mask in the same cycle.
- R7: Reads of 0x08 and 0x0C, and of every offset other than 0x04, 0x10 and 0x20, return zero.
- R8: A read of offset 0x20 raises `rx_pop` for that cycle only and returns `rx_byte` zero-extended.
- R9: A write to offset 0x1C raises `tx_push` for that cycle only, with `tx_byte` equal to data bits [7:0]. Reads of 0x1C raise no push.
- R10: Zero bits written to 0x04 leave the corresponding event bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| evt_pulse | input | 7 | One-cycle event requests, one per status bit |
| rx_not_empty | input | 1 | Live receive FIFO not-empty level |
| tx_not_full | input | 1 | Live transmit FIFO not-full level |
| rx_byte | input | 8 | Head entry of the receive FIFO |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_byte | output | 8 | Byte pushed to the transmit FIFO |
| irq | output | 1 | Interrupt request |

## Verification
Read data, the two FIFO strobes and `irq` are combinational. They are due in the same cycle as the access, level change or register state that causes them. Mask writes, status clears and event pulses take effect at the next rising edge, so their results are due one cycle after the stimulus. The reference model in the bench applies each cycle's inputs to its own state only after it has compared that cycle's outputs. Inputs change on the falling edge, and outputs are sampled a short time later, well clear of the rising edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  typedef struct packed {
    logic wr_status;
    logic wr_enable;
    logic wr_disable;
    logic wr_txd;
    logic rd_status;
    logic rd_mask;
    logic rd_rxd;
  } dec_hits_t;

  // Mask update: ones in set_v add, ones in clr_v remove, clear has priority.
  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic [31:0] set_v,
                                            input logic [31:0] clr_v);
    return (cur | set_v) & ~clr_v;
  endfunction

  // Sticky event update: a new event beats a simultaneous clear.
  function automatic logic [31:0] event_next(input logic [31:0] cur,
                                             input logic [31:0] ev,
                                             input logic [31:0] clr_v);
    return (cur & ~clr_v) | ev;
  endfunction

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFF_STATUS = 8'h04,
  parameter logic [ADDR_W-1:0] OFF_ENABLE = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_DISABLE = 8'h0C,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_TXD    = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_RXD    = 8'h20
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output dec_hits_t         hits
);
  logic wr_acc, rd_acc;
  assign wr_acc = sel & we;
  assign rd_acc = sel & ~we;

  always_comb begin
    hits            = '0;
    hits.wr_status  = wr_acc && (addr == OFF_STATUS);
    hits.wr_enable  = wr_acc && (addr == OFF_ENABLE);
    hits.wr_disable = wr_acc && (addr == OFF_DISABLE);
    hits.wr_txd     = wr_acc && (addr == OFF_TXD);
    hits.rd_status  = rd_acc && (addr == OFF_STATUS);
    hits.rd_mask    = rd_acc && (addr == OFF_MASK);
    hits.rd_rxd     = rd_acc && (addr == OFF_RXD);
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int NSRC = 7,
  parameter logic [NSRC-1:0] LEVEL_BITS = 7'b0010100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] lvl,
  input  logic            clr_en,
  input  logic [NSRC-1:0] clr_data,
  output logic [NSRC-1:0] status_view
);
  logic [NSRC-1:0] clr_v;
  logic [31:0]     nxt_full;
  logic [NSRC-1:0] evt_q;

  assign clr_v    = clr_en ? clr_data : '0;
  assign nxt_full = event_next(32'(evt_q), 32'(ev), 32'(clr_v));

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= nxt_full[NSRC-1:0] & ~LEVEL_BITS;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LEVEL_BITS[i]) begin : g_lvl
      assign status_view[i] = lvl[i];
    end else begin : g_evt
      assign status_view[i] = evt_q[i];
    end
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
#(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [NSRC-1:0] data,
  output logic [NSRC-1:0] mask_q
);
  logic [31:0] nxt_full;
  assign nxt_full = mask_next(32'(mask_q),
                              set_en ? 32'(data) : 32'd0,
                              clr_en ? 32'(data) : 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= nxt_full[NSRC-1:0];
  end
endmodule

// File: rtl/spi_irq_regbank.sv
module spi_irq_regbank
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int NSRC     = 7,
  parameter int RXNE_POS = 4,
  parameter int TXNF_POS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic              rx_not_empty,
  input  logic              tx_not_full,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  localparam logic [NSRC-1:0] LEVEL_BITS =
    NSRC'((1 << RXNE_POS) | (1 << TXNF_POS));

  dec_hits_t       hits;
  logic [NSRC-1:0] lvl_vec;
  logic [NSRC-1:0] status_view;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pending;

  // Named event wires for the checker.
  logic wr_status, wr_enable, wr_disable;
  assign wr_status  = hits.wr_status;
  assign wr_enable  = hits.wr_enable;
  assign wr_disable = hits.wr_disable;

  always_comb begin
    lvl_vec           = '0;
    lvl_vec[RXNE_POS] = rx_not_empty;
    lvl_vec[TXNF_POS] = tx_not_full;
  end

  spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .we   (bus_we),
    .addr (bus_addr),
    .hits (hits)
  );

  spi_irq_status #(.NSRC(NSRC), .LEVEL_BITS(LEVEL_BITS)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (evt_pulse),
    .lvl         (lvl_vec),
    .clr_en      (hits.wr_status),
    .clr_data    (bus_wdata[NSRC-1:0]),
    .status_view (status_view)
  );

  spi_irq_mask #(.NSRC(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (hits.wr_enable),
    .clr_en (hits.wr_disable),
    .data   (bus_wdata[NSRC-1:0]),
    .mask_q (mask_q)
  );

  assign pending = status_view & mask_q;
  assign irq     = |pending;
  assign rx_pop  = hits.rd_rxd;
  assign tx_push = hits.wr_txd;
  assign tx_byte = bus_wdata[BYTE_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (hits.rd_status)   bus_rdata = DATA_W'(status_view);
    else if (hits.rd_mask) bus_rdata = DATA_W'(mask_q);
    else if (hits.rd_rxd)  bus_rdata = DATA_W'(rx_byte);
  end
endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker #(
  parameter int NSRC = 7,
  parameter int DATA_W = 32,
  parameter logic [NSRC-1:0] EVT_BITS = 7'b1101011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wr_status,
  input logic              wr_enable,
  input logic              wr_disable,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   status_view,
  input logic              rx_pop,
  input logic              tx_push,
  input logic              irq
);
  // R2
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  // R2
  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enable && !wr_disable) |=> $stable(mask_q));
  // R3
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));
  // R4
  a_r4_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((status_view & $past(status_view) & EVT_BITS) == ($past(status_view) & EVT_BITS)));
  // R6
  a_r6_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  // R8
  a_r8_pop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_sel && !bus_we));
  // R9
  a_r9_push_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (bus_sel && bus_we));
endmodule

bind spi_irq_regbank spi_irq_checker #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .wr_status   (wr_status),
  .wr_enable   (wr_enable),
  .wr_disable  (wr_disable),
  .mask_q      (mask_q),
  .status_view (status_view),
  .rx_pop      (rx_pop),
  .tx_push     (tx_push),
  .irq         (irq)
);

// File: tb/spi_irq_regbank_test.sv
module spi_irq_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] EVT = 7'b1101011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_pulse = '0;
  logic        rx_not_empty = 1'b0, tx_not_full = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_pop, tx_push, irq;
  logic [7:0]  tx_byte;

  int n_cmp = 0, n_bad = 0;
  int m_mask = 0, m_evt = 0;   // reference model state

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_regbank uut (.*);

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int live_status();
    return (m_evt & EVT) | (rx_not_empty << 4) | (tx_not_full << 2);
  endfunction

  // One bus cycle: drive on falling edge, compare, then advance the model.
  task automatic cyc(bit sel, bit we, int addr, int wd, int ev,
                     bit rxne, bit txnf, int rxb);
    int exp_rd;
    string rtag;
    bus_sel = sel; bus_we = we; bus_addr = 8'(addr); bus_wdata = wd;
    evt_pulse = 7'(ev); rx_not_empty = rxne; tx_not_full = txnf; rx_byte = 8'(rxb);
    #1;
    exp_rd = 0; rtag = "R7";
    if (sel && !we) begin
      if (addr == 'h04) begin exp_rd = live_status(); rtag = "R4/R5"; end
      else if (addr == 'h10) begin exp_rd = m_mask; rtag = "R2/R3"; end
      else if (addr == 'h20) begin exp_rd = rxb & 'hFF; rtag = "R8"; end
      chk(rtag, bus_rdata, exp_rd);
    end
    chk("R6 irq", irq, ((live_status() & m_mask) != 0) ? 1 : 0);
    chk("R8 pop", rx_pop, (sel && !we && addr == 'h20) ? 1 : 0);
    chk("R9 push", tx_push, (sel && we && addr == 'h1C) ? 1 : 0);
    if (sel && we && addr == 'h1C) chk("R9 byte", tx_byte, wd & 'hFF);
    @(posedge clk);
    if (rst_n) begin
      if (sel && we && addr == 'h08) m_mask = m_mask | (wd & 'h7F);
      if (sel && we && addr == 'h0C) m_mask = m_mask & ~wd & 'h7F;
      m_evt = ((sel && we && addr == 'h04) ? (m_evt & ~wd) : m_evt) | (ev & EVT);
      m_evt = m_evt & EVT;
    end
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, rx_not_empty, tx_not_full, 0); endtask
  task automatic wr(int a, int d); cyc(1, 1, a, d, 0, rx_not_empty, tx_not_full, 0); endtask
  task automatic rd(int a); cyc(1, 0, a, 0, 0, rx_not_empty, tx_not_full, 'h5A); endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd('h10); rd('h04); chk("R1 irq", irq, 0);
        // R2: enable sets, zeros leave alone
        wr('h08, 'h05); rd('h10); wr('h08, 'h40); rd('h10);
        // R7: write-only and unused offsets read zero
        rd('h08); rd('h0C); rd('h00); rd('h14); rd('h18); rd('h1C);
        // R4: event latches and sticks
        cyc(0, 0, 0, 0, 'h01, 0, 0, 0); idle(); rd('h04);
        cyc(0, 0, 0, 0, 'h7F, 0, 0, 0); rd('h04);
        // R10: zero bits do not clear
        wr('h04, 'h00); rd('h04);
        wr('h04, 'h02); rd('h04);
        // R4: event and clear together keeps bit
        cyc(1, 1, 'h04, 'h08, 'h08, 0, 0, 0); rd('h04);
        // R5: level bits live and ignore clear/pulse
        cyc(0, 0, 0, 0, 'h14, 1, 0, 0); rd('h04);
        cyc(1, 1, 'h04, 'h14, 0, 1, 1, 0); rd('h04);
        // R3: disable clears; 0x7F masks all
        wr('h0C, 'h01); rd('h10); wr('h08, 'h7F); rd('h10);
        wr('h0C, 'h7F); rd('h10);
        // R6: irq from level source only
        wr('h04, 'h7F); wr('h08, 'h10);
        cyc(0, 0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1, 1, 0);
        // R8 / R9: data strobes
        rd('h20); cyc(1, 0, 'h20, 0, 0, 1, 1, 'hC3);
        wr('h1C, 'h1234_56A7); rd('h1C); idle();
        disable fork;
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule